// File: doc/BRIEF.md
# Single-Cycle RISC Subset Processor

This block is a small processor core that completes one instruction on every clock edge. Each cycle it reads a 32-bit instruction from an internal instruction store at the word selected by the program counter. It decodes the instruction, reads up to two operands from a 32-entry by 32-bit register file, and computes a result or an address. It then writes back to the register file or the data store and moves the program counter, all in the same cycle. It handles register arithmetic (add, subtract, signed set-less-than), immediate arithmetic and logic, upper-half constant loads, word loads and stores, compare-and-branch in both senses, region-relative jumps with and without a return link, and a jump through a register.

Both stores are small internal arrays. Their size is set by one address-width parameter. A surrounding environment fills them through a write-only loader port, normally while reset is held. Two combinational peek ports give the register file and the data store contents, so a program's effect can be examined after it has run. No pipelining is present, so nothing can stall and no instruction can interfere with another.

Top module: `sc_cpu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter becomes 0, every register becomes 0, and no instruction takes effect.
- R2: Opcode 0 selects the register format: source fields at bits 25:21 and 20:16, destination at 15:11, function code at 5:0. Function 32 writes the 32-bit sum and function 34 writes the difference (first minus second), both wrapping modulo 2^32.
- R3: Function 42 (register form) and opcode 10 (immediate form, sign-extended) write 1 when the first operand is less than the second as signed numbers, and 0 otherwise.
- R4: Opcode 8 adds a sign-extended 16-bit immediate (bits 15:0). Opcodes 12 and 13 AND or OR the zero-extended immediate. All three write the register named in bits 20:16.
- R5: Opcode 15 writes the immediate into bits 31:16 of the target register and clears bits 15:0.
- R6: Opcode 35 loads the data-store word at byte address (first source + sign-extended immediate) into the register in bits 20:16. Opcode 43 stores that register to the same address. The word index is byte address bits [AW+1:2].
- R7: Opcode 4 (equal) and opcode 5 (not equal) compare the two sources. When the branch is taken, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4.
- R8: Opcode 2 jumps, and opcode 3 jumps and writes PC+4 into register 31. The target is the upper 4 bits of PC+4, then the 26-bit field in bits 25:0, then two zero bits.
- R9: Register-format function 8 loads the PC from the first source register.
- R10: Register 0 always reads as 0. A write aimed at it leaves it at 0.
- R11: Any other opcode, any other register-format function code, or a register-format instruction with a non-zero shift field (bits 10:6) only advances the PC by 4.
- R12: Every instruction that does not redirect control advances the PC by exactly 4, so the PC stays word-aligned.
- R13: A loader write with `ld_dmem` low fills instruction word `ld_addr`. With `ld_dmem` high it fills data word `ld_addr`, and a loader write takes priority over a store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Loader write strobe |
| ld_dmem | input | 1 | Loader target: 0 instruction store, 1 data store |
| ld_addr | input | AW | Loader word address |
| ld_data | input | 32 | Loader write data |
| pc_o | output | 32 | Current program counter (byte address) |
| peek_reg | input | 5 | Register file peek index |
| peek_reg_data | output | 32 | Value of the peeked register |
| peek_mem | input | AW | Data store peek word address |
| peek_mem_data | output | 32 | Value of the peeked data word |

## Verification
The hardest situation to reach from the ports is control flow: a taken or untaken branch, a jump-and-link, and a return through a register. Each of these leaves no value behind, only a choice of which later instructions run. The stimulus therefore places marker instructions on both arms of every branch and on the instructions a jump must skip. Afterwards it reads which markers wrote their registers and where the PC came to rest. The arithmetic sweep repeats one fixed program over operand triples chosen to hit equal operands, sign boundaries and carry wrap, so both branch senses and both signed-compare results occur.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
// Shared encodings and control types for the single-cycle core.
// Assumes the fixed three-format 32-bit instruction encoding.
package sc_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = 5;

    // Primary opcodes
    localparam logic [5:0] OP_REG  = 6'd0;
    localparam logic [5:0] OP_J    = 6'd2;
    localparam logic [5:0] OP_JAL  = 6'd3;
    localparam logic [5:0] OP_BEQ  = 6'd4;
    localparam logic [5:0] OP_BNE  = 6'd5;
    localparam logic [5:0] OP_ADDI = 6'd8;
    localparam logic [5:0] OP_SLTI = 6'd10;
    localparam logic [5:0] OP_ANDI = 6'd12;
    localparam logic [5:0] OP_ORI  = 6'd13;
    localparam logic [5:0] OP_LUI  = 6'd15;
    localparam logic [5:0] OP_LW   = 6'd35;
    localparam logic [5:0] OP_SW   = 6'd43;

    // Register-format function codes
    localparam logic [5:0] FN_JR  = 6'd8;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND, ALU_OR, ALU_HI
    } alu_op_t;

    typedef enum logic [1:0] {
        DST_RD, DST_RT, DST_LINK
    } dst_t;

    typedef enum logic [1:0] {
        WB_ALU, WB_MEM, WB_PC4
    } wb_t;

    typedef struct packed {
        logic    reg_we;
        dst_t    dst;
        wb_t     wb;
        logic    use_imm;
        logic    imm_zext;
        alu_op_t alu_op;
        logic    mem_we;
        logic    br_eq;
        logic    br_ne;
        logic    jump;
        logic    jump_reg;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
// Instruction decoder: turns one 32-bit instruction word into control.
// Assumes opcode at 31:26, function at 5:0, shift field at 10:6.
// Anything not recognised yields all-zero control, i.e. a plain PC+4 step.
module sc_decode
    import sc_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl
);

    logic [5:0] op;
    logic [5:0] fn;
    logic [4:0] sh;
    logic [14:0] fields_unused;

    assign op = instr[31:26];
    assign fn = instr[5:0];
    assign sh = instr[10:6];
    // register and immediate fields are consumed by the datapath, not here
    assign fields_unused = instr[25:11];

    // Combinational control table
    always_comb begin
        ctrl = '0;
        unique case (op)
            OP_REG: begin
                if (sh == 5'd0) begin
                    unique case (fn)
                        FN_ADD: begin
                            ctrl.reg_we = 1'b1;
                            ctrl.dst    = DST_RD;
                            ctrl.alu_op = ALU_ADD;
                        end
                        FN_SUB: begin
                            ctrl.reg_we = 1'b1;
                            ctrl.dst    = DST_RD;
                            ctrl.alu_op = ALU_SUB;
                        end
                        FN_SLT: begin
                            ctrl.reg_we = 1'b1;
                            ctrl.dst    = DST_RD;
                            ctrl.alu_op = ALU_SLT;
                        end
                        FN_JR: begin
                            ctrl.jump_reg = 1'b1;
                        end
                        default: ctrl = '0;
                    endcase
                end
            end
            OP_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.dst     = DST_RT;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_ADD;
            end
            OP_SLTI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.dst     = DST_RT;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_SLT;
            end
            OP_ANDI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.dst      = DST_RT;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_zext = 1'b1;
                ctrl.alu_op   = ALU_AND;
            end
            OP_ORI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.dst      = DST_RT;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_zext = 1'b1;
                ctrl.alu_op   = ALU_OR;
            end
            OP_LUI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.dst      = DST_RT;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_zext = 1'b1;
                ctrl.alu_op   = ALU_HI;
            end
            OP_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.dst     = DST_RT;
                ctrl.wb      = WB_MEM;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_ADD;
            end
            OP_SW: begin
                ctrl.mem_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_ADD;
            end
            OP_BEQ: ctrl.br_eq = 1'b1;
            OP_BNE: ctrl.br_ne = 1'b1;
            OP_J:   ctrl.jump  = 1'b1;
            OP_JAL: begin
                ctrl.jump   = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.dst    = DST_LINK;
                ctrl.wb     = WB_PC4;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
// Register file: NREG words, two operand read ports plus one peek port,
// one write port. Entry 0 is hardwired to zero. Cleared by reset.
module sc_regfile
    import sc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RIDX-1:0] waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RIDX-1:0] ra_a,
    output logic [XLEN-1:0] rd_a,
    input  logic [RIDX-1:0] ra_b,
    output logic [XLEN-1:0] rd_b,
    input  logic [RIDX-1:0] ra_p,
    output logic [XLEN-1:0] rd_p
);

    logic [XLEN-1:0] regs [NREG];

    // Storage update: clear on reset, otherwise accept non-zero writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports; index 0 forced to zero
    always_comb begin
        rd_a = (ra_a == '0) ? '0 : regs[ra_a];
        rd_b = (ra_b == '0) ? '0 : regs[ra_b];
        rd_p = (ra_p == '0) ? '0 : regs[ra_p];
    end

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
// Arithmetic/logic unit. Assumes operand b already carries the
// extended immediate when an immediate form is executing.
module sc_alu
    import sc_pkg::*;
(
    input  alu_op_t         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    // Result select
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_HI:  y = {b[15:0], 16'h0000};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sc_nextpc.sv
`timescale 1ns/1ps
// Next-PC selection: register jump, region jump, taken branch, or PC+4.
// Assumes at most one of the control flags is set per instruction.
module sc_nextpc
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  logic [15:0]     imm,
    input  logic [25:0]     target,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic            br_eq,
    input  logic            br_ne,
    input  logic            jump,
    input  logic            jump_reg,
    output logic [XLEN-1:0] pc_plus4,
    output logic [XLEN-1:0] pc_next
);

    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] j_target;
    logic            same;
    logic            take;

    // Candidate targets and branch decision
    always_comb begin
        pc_plus4  = pc + 32'd4;
        br_target = pc_plus4 + {{14{imm[15]}}, imm, 2'b00};
        j_target  = {pc_plus4[31:28], target, 2'b00};
        same      = (src_a == src_b);
        take      = (br_eq && same) || (br_ne && !same);
    end

    // Priority select of the next fetch address
    always_comb begin
        if (jump_reg)  pc_next = src_a;
        else if (jump) pc_next = j_target;
        else if (take) pc_next = br_target;
        else           pc_next = pc_plus4;
    end

endmodule

// File: rtl/sc_cpu.sv
`timescale 1ns/1ps
// Single-cycle core top: PC register, instruction and data stores,
// decoder, register file, ALU and next-PC logic. One instruction per
// clock. Stores are filled through the loader port, normally in reset.
module sc_cpu
    import sc_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic          ld_dmem,
    input  logic [AW-1:0] ld_addr,
    input  logic [31:0]   ld_data,
    output logic [31:0]   pc_o,
    input  logic [4:0]    peek_reg,
    output logic [31:0]   peek_reg_data,
    input  logic [AW-1:0] peek_mem,
    output logic [31:0]   peek_mem_data
);

    localparam int WORDS = 1 << AW;

    logic [XLEN-1:0] imem [WORDS];
    logic [XLEN-1:0] dmem [WORDS];

    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] instr;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] load_val;
    logic            rf_we;
    logic [RIDX-1:0] wr_idx;
    logic [XLEN-1:0] wr_data;
    logic [AW-1:0]   daddr;

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    // Instruction store fill from the loader
    always_ff @(posedge clk) begin
        if (ld_we && !ld_dmem) imem[ld_addr] <= ld_data;
    end

    // Data store fill from the loader, else store-word outside reset
    always_ff @(posedge clk) begin
        if (ld_we && ld_dmem)         dmem[ld_addr] <= ld_data;
        else if (rst_n && ctrl.mem_we) dmem[daddr] <= rt_val;
    end

    // Fetch and data-store reads
    always_comb begin
        instr         = imem[pc[AW+1:2]];
        daddr         = alu_y[AW+1:2];
        load_val      = dmem[daddr];
        peek_mem_data = dmem[peek_mem];
    end

    sc_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    // Immediate extension and second ALU operand
    always_comb begin
        imm_ext = ctrl.imm_zext ? {16'h0000, instr[15:0]}
                                : {{16{instr[15]}}, instr[15:0]};
        alu_b   = ctrl.use_imm ? imm_ext : rt_val;
    end

    // Write-back destination and data
    always_comb begin
        rf_we = ctrl.reg_we && rst_n;
        unique case (ctrl.dst)
            DST_RT:   wr_idx = instr[20:16];
            DST_LINK: wr_idx = 5'd31;
            default:  wr_idx = instr[15:11];
        endcase
        unique case (ctrl.wb)
            WB_MEM:  wr_data = load_val;
            WB_PC4:  wr_data = pc_plus4;
            default: wr_data = alu_y;
        endcase
    end

    sc_regfile u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (wr_idx),
        .wdata (wr_data),
        .ra_a  (instr[25:21]),
        .rd_a  (rs_val),
        .ra_b  (instr[20:16]),
        .rd_b  (rt_val),
        .ra_p  (peek_reg),
        .rd_p  (peek_reg_data)
    );

    sc_alu u_alu (
        .op (ctrl.alu_op),
        .a  (rs_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    sc_nextpc u_npc (
        .pc       (pc),
        .imm      (instr[15:0]),
        .target   (instr[25:0]),
        .src_a    (rs_val),
        .src_b    (rt_val),
        .br_eq    (ctrl.br_eq),
        .br_ne    (ctrl.br_ne),
        .jump     (ctrl.jump),
        .jump_reg (ctrl.jump_reg),
        .pc_plus4 (pc_plus4),
        .pc_next  (pc_next)
    );

    assign pc_o = pc;

endmodule

// File: rtl/sc_cpu_checks.sv
`timescale 1ns/1ps
// Property checker for sc_cpu, attached by bind. Observes the PC,
// decoded control, operand reads and the register write port.
module sc_cpu_checks (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic        is_beq,
    input logic        is_bne,
    input logic        is_jump,
    input logic        is_jreg,
    input logic        is_link,
    input logic [4:0]  rs_idx,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [15:0] imm,
    input logic        rf_we,
    input logic [4:0]  rf_waddr,
    input logic [31:0] rf_wdata
);

    logic [31:0] boff;
    logic        taken;
    logic        redirect;

    assign boff     = {{14{imm[15]}}, imm, 2'b00};
    assign taken    = (is_beq && (rs_val == rt_val)) || (is_bne && (rs_val != rt_val));
    assign redirect = is_beq || is_bne || is_jump || is_jreg;

    // R1: a reset cycle leaves the PC at zero
    a_r1_pc_cleared: assert property (@(posedge clk)
        !rst_n |=> (pc == 32'd0));

    // R10: reading index 0 always yields zero
    a_r10_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_idx == 5'd0) |-> (rs_val == 32'd0));

    // R7: a taken branch lands at PC+4 plus the scaled offset
    a_r7_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> (pc == $past(pc) + 32'd4 + $past(boff)));

    // R9: register jump loads the PC from the first source
    a_r9_jump_reg: assert property (@(posedge clk) disable iff (!rst_n)
        is_jreg |=> (pc == $past(rs_val)));

    // R8: jump-and-link writes PC+4 into register 31
    a_r8_link_write: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jump && is_link) |-> (rf_we && (rf_waddr == 5'd31) && (rf_wdata == pc + 32'd4)));

    // R12: non-redirecting instructions step the PC by four
    a_r12_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> (pc == $past(pc) + 32'd4));

    // R12: the PC is always word-aligned
    a_r12_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

endmodule

bind sc_cpu sc_cpu_checks u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc),
    .is_beq   (ctrl.br_eq),
    .is_bne   (ctrl.br_ne),
    .is_jump  (ctrl.jump),
    .is_jreg  (ctrl.jump_reg),
    .is_link  (ctrl.dst == sc_pkg::DST_LINK),
    .rs_idx   (instr[25:21]),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .imm      (instr[15:0]),
    .rf_we    (rf_we),
    .rf_waddr (wr_idx),
    .rf_wdata (wr_data)
);

// File: tb/sc_cpu_test.sv
`timescale 1ns/1ps
module sc_cpu_test;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_we = 1'b0;
    logic          ld_dmem = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [31:0]   pc_o;
    logic [4:0]    peek_reg = '0;
    logic [31:0]   peek_reg_data;
    logic [AW-1:0] peek_mem = '0;
    logic [31:0]   peek_mem_data;

    int checks = 0;
    int failures = 0;
    logic [31:0] prog [32];
    int plen = 0;

    sc_cpu #(.AW(AW)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld_we         (ld_we),
        .ld_dmem       (ld_dmem),
        .ld_addr       (ld_addr),
        .ld_data       (ld_data),
        .pc_o          (pc_o),
        .peek_reg      (peek_reg),
        .peek_reg_data (peek_reg_data),
        .peek_mem      (peek_mem),
        .peek_mem_data (peek_mem_data)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] im);
        return {op, 5'(rs), 5'(rt), im};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] t);
        return {op, t};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_is(input string tag, input int r, input logic [31:0] exp);
        peek_reg = 5'(r);
        #1;
        chk(tag, peek_reg_data, exp);
    endtask

    task automatic mem_is(input string tag, input int a, input logic [31:0] exp);
        peek_mem = a[AW-1:0];
        #1;
        chk(tag, peek_mem_data, exp);
    endtask

    task automatic put(input logic sel, input int a, input logic [31:0] d);
        @(negedge clk);
        ld_we   = 1'b1;
        ld_dmem = sel;
        ld_addr = a[AW-1:0];
        ld_data = d;
    endtask

    // Enter reset and fill the instruction store from prog[]
    task automatic begin_load();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < plen; i++) put(1'b0, i, prog[i]);
    endtask

    // Close the loader, confirm reset state, release and run n cycles
    task automatic run(input int n);
        @(negedge clk);
        ld_we = 1'b0;
        chk("R1 pc in reset", pc_o, 32'd0);
        reg_is("R1 reg3 cleared", 3, 32'd0);
        reg_is("R1 reg31 cleared", 31, 32'd0);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    localparam logic [5:0] OP_J = 6'd2, OP_JAL = 6'd3, OP_BEQ = 6'd4, OP_BNE = 6'd5;
    localparam logic [5:0] OP_ADDI = 6'd8, OP_SLTI = 6'd10, OP_ANDI = 6'd12, OP_ORI = 6'd13;
    localparam logic [5:0] OP_LUI = 6'd15, OP_LW = 6'd35, OP_SW = 6'd43;
    localparam logic [5:0] FN_JR = 6'd8, FN_ADD = 6'd32, FN_SUB = 6'd34, FN_SLT = 6'd42;

    logic [31:0] va [8];
    logic [31:0] vb [8];
    logic [15:0] vi [8];

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        va[0] = 32'd5;          vb[0] = 32'd5;          vi[0] = 16'h0003;
        va[1] = 32'd7;          vb[1] = 32'd9;          vi[1] = 16'hFFFF;
        va[2] = 32'h80000000;   vb[2] = 32'd1;          vi[2] = 16'h8000;
        va[3] = 32'hFFFFFFFF;   vb[3] = 32'd0;          vi[3] = 16'h7FFF;
        va[4] = 32'h12345678;   vb[4] = 32'h9ABCDEF0;   vi[4] = 16'h00F0;
        va[5] = 32'd1;          vb[5] = 32'h80000000;   vi[5] = 16'h0001;
        va[6] = 32'd0;          vb[6] = 32'd0;          vi[6] = 16'h0000;
        va[7] = 32'h7FFFFFFF;   vb[7] = 32'hFFFFFFFF;   vi[7] = 16'hFFFE;

        repeat (3) @(negedge clk);
        chk("R1 pc after power-up reset", pc_o, 32'd0);

        // Arithmetic, memory and branch-sense sweep
        for (int k = 0; k < 8; k++) begin
            logic [31:0] a, b, s, z;
            a = va[k]; b = vb[k];
            s = {{16{vi[k][15]}}, vi[k]};
            z = {16'h0000, vi[k]};
            prog[0]  = enc_i(OP_LUI, 0, 1, a[31:16]);
            prog[1]  = enc_i(OP_ORI, 1, 1, a[15:0]);
            prog[2]  = enc_i(OP_LUI, 0, 2, b[31:16]);
            prog[3]  = enc_i(OP_ORI, 2, 2, b[15:0]);
            prog[4]  = enc_r(FN_ADD, 1, 2, 3);
            prog[5]  = enc_r(FN_SUB, 1, 2, 4);
            prog[6]  = enc_r(FN_SLT, 1, 2, 5);
            prog[7]  = enc_i(OP_SLTI, 1, 6, vi[k]);
            prog[8]  = enc_i(OP_ANDI, 1, 7, vi[k]);
            prog[9]  = enc_i(OP_ORI, 2, 8, vi[k]);
            prog[10] = enc_i(OP_ADDI, 1, 9, vi[k]);
            prog[11] = enc_i(OP_ADDI, 0, 13, 16'd16);
            prog[12] = enc_i(OP_SW, 13, 3, 16'hFFFC);
            prog[13] = enc_i(OP_LW, 0, 10, 16'd12);
            prog[14] = enc_i(OP_BEQ, 1, 2, 16'd1);
            prog[15] = enc_i(OP_ADDI, 0, 11, 16'd1);
            prog[16] = enc_i(OP_BNE, 1, 2, 16'd1);
            prog[17] = enc_i(OP_ADDI, 0, 12, 16'd1);
            prog[18] = enc_i(OP_LW, 0, 14, 16'd20);
            prog[19] = enc_i(OP_LUI, 0, 15, vi[k]);
            prog[20] = enc_i(OP_BEQ, 0, 0, 16'hFFFF);
            plen = 21;
            begin_load();
            put(1'b1, 3, 32'hDEADBEEF);
            put(1'b1, 5, a ^ b);
            run(30);
            reg_is("R5 lui+ori builds operand a", 1, a);
            reg_is("R5 lui+ori builds operand b", 2, b);
            reg_is("R2 add", 3, a + b);
            reg_is("R2 sub", 4, a - b);
            reg_is("R3 slt", 5, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
            reg_is("R3 slti", 6, ($signed(a) < $signed(s)) ? 32'd1 : 32'd0);
            reg_is("R4 andi zero-extended", 7, a & z);
            reg_is("R4 ori zero-extended", 8, b | z);
            reg_is("R4 addi sign-extended", 9, a + s);
            reg_is("R6 lw after sw", 10, a + b);
            reg_is("R7 beq marker", 11, (a == b) ? 32'd0 : 32'd1);
            reg_is("R7 bne marker", 12, (a != b) ? 32'd0 : 32'd1);
            reg_is("R6 lw of loader word", 14, a ^ b);
            reg_is("R5 lui clears low half", 15, {vi[k], 16'h0000});
            mem_is("R6 sw negative offset", 3, a + b);
            mem_is("R13 loader data word", 5, a ^ b);
            chk("R12 pc parked at loop", pc_o, 32'd80);
        end

        // Control-flow program
        for (int i = 0; i < 32; i++) prog[i] = 32'd0;
        prog[0]  = enc_i(OP_ADDI, 0, 1, 16'd5);
        prog[1]  = enc_i(OP_ADDI, 0, 2, 16'd5);
        prog[2]  = enc_i(OP_BEQ, 1, 2, 16'd2);
        prog[3]  = enc_i(OP_ADDI, 0, 3, 16'd1);
        prog[4]  = enc_i(OP_ADDI, 0, 3, 16'd2);
        prog[5]  = enc_i(OP_BNE, 1, 2, 16'd1);
        prog[6]  = enc_i(OP_ADDI, 0, 4, 16'd7);
        prog[7]  = enc_j(OP_JAL, 26'd12);
        prog[8]  = enc_i(OP_ADDI, 0, 5, 16'd9);
        prog[9]  = enc_j(OP_J, 26'd15);
        prog[10] = enc_i(OP_ADDI, 0, 6, 16'd1);
        prog[11] = enc_i(OP_ADDI, 0, 6, 16'd1);
        prog[12] = enc_i(OP_ADDI, 0, 7, 16'd3);
        prog[13] = enc_r(FN_JR, 31, 0, 0);
        prog[14] = enc_i(OP_ADDI, 0, 6, 16'd1);
        prog[15] = enc_i(6'h3F, 0, 8, 16'h1234);
        prog[16] = enc_i(OP_ADDI, 0, 0, 16'd99);
        prog[17] = {6'd0, 5'd1, 5'd2, 5'd9, 5'd3, FN_ADD};
        prog[18] = enc_r(6'd63, 1, 2, 10);
        prog[19] = enc_i(OP_BEQ, 0, 0, 16'hFFFF);
        plen = 20;
        begin_load();
        run(25);
        reg_is("R7 taken beq skipped markers", 3, 32'd0);
        reg_is("R7 untaken bne fell through", 4, 32'd7);
        reg_is("R8 jal link value", 31, 32'd32);
        reg_is("R8 jal reached target", 7, 32'd3);
        reg_is("R9 jr returned to link", 5, 32'd9);
        reg_is("R8 j skipped markers", 6, 32'd0);
        reg_is("R11 unknown opcode wrote nothing", 8, 32'd0);
        reg_is("R10 write to reg0 ignored", 0, 32'd0);
        reg_is("R11 nonzero shift field is no-op", 9, 32'd0);
        reg_is("R11 unknown function is no-op", 10, 32'd0);
        chk("R12 pc parked at loop", pc_o, 32'd76);

        // Region jump keeps upper PC bits (here zero) and forward loop
        prog[0] = enc_j(OP_J, 26'd3);
        prog[1] = enc_i(OP_ADDI, 0, 1, 16'd1);
        prog[2] = enc_i(OP_ADDI, 0, 1, 16'd1);
        prog[3] = enc_i(OP_ADDI, 0, 2, 16'hFFFF);
        prog[4] = enc_j(OP_J, 26'd4);
        plen = 5;
        begin_load();
        run(6);
        reg_is("R8 j skipped words 1-2", 1, 32'd0);
        reg_is("R4 addi -1 sign-extends", 2, 32'hFFFFFFFF);
        chk("R8 self jump holds pc", pc_o, 32'd16);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule